// File: doc/BRIEF.md
# DRAM Command Arbiter with Four-Activate Window

The arbiter picks at most one command per clock for a DDR2-style memory device. It has five sources. Column (CAS) requests, reads and writes come from outside the block. Refresh and scrub requests come from two interval timers inside the block. A fixed priority chooses among the sources that are eligible. The grant and the command word are combinational outputs, so they appear in the same cycle as the requests that cause them.

Scrub, read and write commands each open a row, so each one counts as an activate. A rolling limiter keeps the ages of the four most recent activates. It withholds every activate-type command while four activates already lie inside the configured window. A read whose full address equals that of a write requested in the same cycle is a read-after-write hazard. The arbiter holds that read back and lets the lower-priority write go first.

The refresh interval, scrub interval and window length are configuration inputs. They are loaded during startup and kept constant after that.

Top module: `dram_cmd_arb`

## Requirements
- R1: While reset is active, and in every cycle after it with no external request and no timer pending, `cmd_valid` is 0, `cmd_kind` is 0, `cmd_bank` is 0 and all grants are 0.
- R2: Among the eligible sources, refresh wins over CAS, CAS over scrub, scrub over read, and read over write. `cmd_kind` encodes the winner as 1=refresh, 2=CAS, 3=scrub, 4=read, 5=write, and 0 means no command.
- R3: Refresh becomes pending `cfg_ref_intv` cycles after reset is released. After a refresh grant in cycle g, it becomes pending again in cycle g+1+`cfg_ref_intv`. Cycle 0 is the first cycle after reset is released. A pending refresh stays pending until it is granted, and it issues with bank 0.
- R4: Scrub becomes pending on the same schedule as R3, but uses `cfg_scrub_intv`, and it stays pending until it is granted. Successive scrub commands carry bank 0, 1, 2 and so on, wrapping modulo 8.
- R5: Scrub, read and write count as activates. An activate may issue in cycle t only if fewer than four activates issued in cycles t-`cfg_tfaw`+1 through t-1. When the window is full, all three are withheld, while refresh and CAS are unaffected.
- R6: When `rd_req` and `wr_req` are both high and all 32 bits of `rd_addr` equal `wr_addr`, the read is not granted and the write may issue. An address that differs in any single bit, including bit 31, is not a hazard.
- R7: At most one of `cas_gnt`, `rd_gnt` and `wr_gnt` is high. `cmd_valid` is high exactly when `cmd_kind` is non-zero. `cmd_bank` carries the bank of the granted source, and all grants and the command word appear in the same cycle as the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ref_intv | input | 13 | Refresh interval in cycles (1 or more), constant after startup |
| cfg_scrub_intv | input | 12 | Scrub interval in cycles (1 or more), constant after startup |
| cfg_tfaw | input | 6 | Four-activate window length in cycles |
| cas_req | input | 1 | Column command request |
| cas_bank | input | 3 | Bank of the column command |
| cas_gnt | output | 1 | Column command granted this cycle |
| rd_req | input | 1 | Read request |
| rd_addr | input | 32 | Read address |
| rd_bank | input | 3 | Read bank |
| rd_gnt | output | 1 | Read granted this cycle |
| wr_req | input | 1 | Write request |
| wr_addr | input | 32 | Write address |
| wr_bank | input | 3 | Write bank |
| wr_gnt | output | 1 | Write granted this cycle |
| cmd_valid | output | 1 | A command is issued this cycle |
| cmd_kind | output | 3 | Issued command type (encoding in R2) |
| cmd_bank | output | 3 | Bank of the issued command |

## Verification
Grants and the command word depend combinationally on the requests and the registered state, so they are due in the very cycle the request is driven. The bench drives inputs at the falling edge and samples one time unit before the next rising edge. Timer and window state changes at the rising edge after a grant, so the reference model updates its due times and activate history only after that cycle's comparison. This keeps a timer becoming pending in cycle g+1+interval, and the age of an activate, aligned with the registered behaviour.

// File: rtl/dram_cmd_arb.sv
module dram_cmd_arb #(
  parameter int ADDR_W = 32,
  parameter int BANK_W = 3,
  parameter int REF_W  = 13,
  parameter int SCRB_W = 12,
  parameter int FAW_W  = 6,
  parameter int FAW_N  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REF_W-1:0]  cfg_ref_intv,
  input  logic [SCRB_W-1:0] cfg_scrub_intv,
  input  logic [FAW_W-1:0]  cfg_tfaw,
  input  logic              cas_req,
  input  logic [BANK_W-1:0] cas_bank,
  output logic              cas_gnt,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [BANK_W-1:0] rd_bank,
  output logic              rd_gnt,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BANK_W-1:0] wr_bank,
  output logic              wr_gnt,
  output logic              cmd_valid,
  output logic [2:0]        cmd_kind,
  output logic [BANK_W-1:0] cmd_bank
);
  localparam logic [2:0] K_NONE = 3'd0, K_REF = 3'd1, K_CAS = 3'd2,
                         K_SCRB = 3'd3, K_RD = 3'd4, K_WR = 3'd5;
  localparam logic [FAW_W-1:0] AGE_MAX = '1;

  logic              ref_pend, scrub_pend;
  logic [REF_W-1:0]  ref_cnt;
  logic [SCRB_W-1:0] scrub_cnt;
  logic [BANK_W-1:0] scrub_bank;
  logic [FAW_W-1:0]  act_age [FAW_N];

  logic faw_ok, raw_hit, ref_go, cas_go, scrub_go, rd_go, wr_go, act_go;

  assign faw_ok   = act_age[FAW_N-1] >= cfg_tfaw;
  assign raw_hit  = rd_req && wr_req && (rd_addr == wr_addr);
  assign ref_go   = ref_pend;
  assign cas_go   = !ref_go && cas_req;
  assign scrub_go = !ref_go && !cas_req && scrub_pend && faw_ok;
  assign rd_go    = !ref_go && !cas_req && !scrub_pend && faw_ok && rd_req && !raw_hit;
  assign wr_go    = !ref_go && !cas_req && !scrub_pend && faw_ok && !rd_go && wr_req;
  assign act_go   = scrub_go || rd_go || wr_go;

  assign cas_gnt   = cas_go;
  assign rd_gnt    = rd_go;
  assign wr_gnt    = wr_go;
  assign cmd_valid = ref_go || cas_go || act_go;

  always_comb begin
    cmd_kind = K_NONE;
    cmd_bank = '0;
    if (ref_go)        cmd_kind = K_REF;
    else if (cas_go)   begin cmd_kind = K_CAS;  cmd_bank = cas_bank;   end
    else if (scrub_go) begin cmd_kind = K_SCRB; cmd_bank = scrub_bank; end
    else if (rd_go)    begin cmd_kind = K_RD;   cmd_bank = rd_bank;    end
    else if (wr_go)    begin cmd_kind = K_WR;   cmd_bank = wr_bank;    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_cnt  <= '0;
      ref_pend <= 1'b0;
    end else if (ref_go) begin
      ref_cnt  <= '0;
      ref_pend <= 1'b0;
    end else if (!ref_pend) begin
      if (ref_cnt == cfg_ref_intv - 1'b1) begin
        ref_cnt  <= '0;
        ref_pend <= 1'b1;
      end else begin
        ref_cnt <= ref_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scrub_cnt  <= '0;
      scrub_pend <= 1'b0;
      scrub_bank <= '0;
    end else if (scrub_go) begin
      scrub_cnt  <= '0;
      scrub_pend <= 1'b0;
      scrub_bank <= scrub_bank + 1'b1;
    end else if (!scrub_pend) begin
      if (scrub_cnt == cfg_scrub_intv - 1'b1) begin
        scrub_cnt  <= '0;
        scrub_pend <= 1'b1;
      end else begin
        scrub_cnt <= scrub_cnt + 1'b1;
      end
    end
  end

  function automatic logic [FAW_W-1:0] age_inc(input logic [FAW_W-1:0] a);
    return (a == AGE_MAX) ? a : a + 1'b1;
  endfunction

  for (genvar i = 0; i < FAW_N; i++) begin : g_age
    always_ff @(posedge clk) begin
      if (!rst_n)
        act_age[i] <= AGE_MAX;
      else if (act_go)
        act_age[i] <= (i == 0) ? FAW_W'(1) : age_inc(act_age[(i == 0) ? 0 : i-1]);
      else
        act_age[i] <= age_inc(act_age[i]);
    end
  end
endmodule

module dram_cmd_arb_chk #(
  parameter int ADDR_W = 32,
  parameter int FAW_W  = 6,
  parameter int FAW_N  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [FAW_W-1:0]  cfg_tfaw,
  input logic              cas_req,
  input logic              rd_req,
  input logic              wr_req,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              cas_gnt,
  input logic              rd_gnt,
  input logic              wr_gnt,
  input logic              cmd_valid,
  input logic [2:0]        cmd_kind,
  input logic              ref_pend,
  input logic              scrub_pend
);
  logic [31:0] tick;
  logic [31:0] stamp [FAW_N];
  logic [2:0]  nact;
  logic        is_act;

  assign is_act = (cmd_kind == 3'd3) || (cmd_kind == 3'd4) || (cmd_kind == 3'd5);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick <= '0;
      nact <= '0;
      for (int i = 0; i < FAW_N; i++) stamp[i] <= '0;
    end else begin
      tick <= tick + 1;
      if (is_act) begin
        stamp[0] <= tick;
        for (int i = 1; i < FAW_N; i++) stamp[i] <= stamp[i-1];
        if (nact < 3'(FAW_N)) nact <= nact + 1'b1;
      end
    end
  end

  // R7
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cas_gnt, rd_gnt, wr_gnt}) && (cmd_valid == (cmd_kind != 3'd0)));
  // R2
  ref_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pend |-> (cmd_kind == 3'd1));
  // R2
  cas_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_req && !ref_pend) |-> cas_gnt);
  // R4
  scrub_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scrub_pend && cmd_kind != 3'd3) |=> scrub_pend);
  // R6
  raw_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && wr_req && rd_addr == wr_addr) |-> !rd_gnt);
  // R5
  faw_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_act && nact == 3'(FAW_N)) |-> ((tick - stamp[FAW_N-1]) >= 32'(cfg_tfaw)));
endmodule

bind dram_cmd_arb dram_cmd_arb_chk #(.ADDR_W(ADDR_W), .FAW_W(FAW_W), .FAW_N(FAW_N)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_tfaw(cfg_tfaw), .cas_req(cas_req),
  .rd_req(rd_req), .wr_req(wr_req), .rd_addr(rd_addr), .wr_addr(wr_addr),
  .cas_gnt(cas_gnt), .rd_gnt(rd_gnt), .wr_gnt(wr_gnt), .cmd_valid(cmd_valid),
  .cmd_kind(cmd_kind), .ref_pend(ref_pend), .scrub_pend(scrub_pend)
);

// File: tb/tb_dram_cmd_arb.sv
module tb_dram_cmd_arb;
  localparam int CLK_PERIOD = 10;
  localparam int REF_I = 37, SCRB_I = 23, TFAW = 10;

  logic clk = 0, rst_n = 0;
  logic [12:0] cfg_ref_intv = 13'(REF_I);
  logic [11:0] cfg_scrub_intv = 12'(SCRB_I);
  logic [5:0]  cfg_tfaw = 6'(TFAW);
  logic cas_req = 0, rd_req = 0, wr_req = 0;
  logic [2:0] cas_bank = 0, rd_bank = 0, wr_bank = 0;
  logic [31:0] rd_addr = 0, wr_addr = 0;
  logic cas_gnt, rd_gnt, wr_gnt, cmd_valid;
  logic [2:0] cmd_kind, cmd_bank;

  dram_cmd_arb dut (
    .clk(clk), .rst_n(rst_n), .cfg_ref_intv(cfg_ref_intv), .cfg_scrub_intv(cfg_scrub_intv),
    .cfg_tfaw(cfg_tfaw), .cas_req(cas_req), .cas_bank(cas_bank), .cas_gnt(cas_gnt),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_bank(rd_bank), .rd_gnt(rd_gnt),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_bank(wr_bank), .wr_gnt(wr_gnt),
    .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_bank(cmd_bank)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0;
  int cyc = 0;
  int ref_due = REF_I, scrub_due = SCRB_I, scrub_bank = 0;
  int acts[$];
  bit done = 0;

  task automatic check_out(input string tag, input int ek, input int eb,
                           input bit ec, input bit er, input bit ew);
    total++;
    if (cmd_kind !== 3'(ek) || cmd_bank !== 3'(eb) || cas_gnt !== ec || rd_gnt !== er ||
        wr_gnt !== ew || cmd_valid !== (ek != 0)) begin
      bad++;
      $display("FAIL %s cyc=%0d actual kind=%0d bank=%0d c/r/w=%b%b%b valid=%b expected kind=%0d bank=%0d c/r/w=%b%b%b",
               tag, cyc, cmd_kind, cmd_bank, cas_gnt, rd_gnt, wr_gnt, cmd_valid,
               ek, eb, ec, er, ew);
    end
  endtask

  // inputs are driven at a falling edge before this is called
  task automatic step(input string tag);
    int ek, eb;
    bit ok, rp, sp, hz;
    #(CLK_PERIOD/2 - 1);
    rp = (cyc >= ref_due);
    sp = (cyc >= scrub_due);
    ok = (acts.size() < 4) || (cyc - acts[acts.size()-4] >= TFAW);
    hz = rd_req && wr_req && (rd_addr == wr_addr);
    ek = 0; eb = 0;
    if (rp) ek = 1;
    else if (cas_req) begin ek = 2; eb = cas_bank; end
    else if (sp) begin if (ok) begin ek = 3; eb = scrub_bank; end end
    else if (ok && rd_req && !hz) begin ek = 4; eb = rd_bank; end
    else if (ok && wr_req) begin ek = 5; eb = wr_bank; end
    check_out(tag, ek, eb, ek == 2, ek == 4, ek == 5);
    @(posedge clk);
    if (ek == 1) ref_due = cyc + 1 + REF_I;
    if (ek == 3) begin scrub_due = cyc + 1 + SCRB_I; scrub_bank = (scrub_bank + 1) % 8; end
    if (ek >= 3) acts.push_back(cyc);
    cyc++;
    @(negedge clk);
  endtask

  task automatic idle();
    cas_req = 0; rd_req = 0; wr_req = 0;
  endtask

  initial begin
    idle();
    repeat (3) @(negedge clk);
    // R1: outputs quiet under reset
    #1 check_out("R1", 0, 0, 0, 0, 0);
    @(negedge clk);
    rst_n = 1;
    // R1 quiet after reset, R3/R4 timer schedules with no traffic
    for (int i = 0; i < 20; i++) step("R1");
    for (int i = 0; i < 130; i++) step("R3");
    // R4: scrub bank walk, scrubs under light read traffic
    for (int i = 0; i < 200; i++) begin
      rd_req = ($urandom % 4 == 0); rd_addr = $urandom; rd_bank = 3'($urandom);
      step("R4");
    end
    // R2: dense mixed traffic for priority
    for (int i = 0; i < 300; i++) begin
      cas_req = ($urandom % 3 == 0); cas_bank = 3'($urandom);
      rd_req = ($urandom % 2 == 0); rd_addr = $urandom; rd_bank = 3'($urandom);
      wr_req = ($urandom % 2 == 0); wr_addr = $urandom; wr_bank = 3'($urandom);
      step("R2");
    end
    // R5: saturating activates against the window
    for (int i = 0; i < 200; i++) begin
      cas_req = ($urandom % 8 == 0); cas_bank = 3'($urandom);
      rd_req = 1; rd_addr = $urandom; rd_bank = 3'($urandom);
      wr_req = 1; wr_addr = ~rd_addr; wr_bank = 3'($urandom);
      step("R5");
    end
    // R6: matching addresses, and near misses incl. bit 31
    for (int i = 0; i < 250; i++) begin
      cas_req = 0;
      rd_req = 1; rd_addr = $urandom; rd_bank = 3'($urandom);
      wr_req = 1; wr_bank = 3'($urandom);
      case ($urandom % 3)
        0: wr_addr = rd_addr;
        1: wr_addr = rd_addr ^ 32'h8000_0000;
        default: wr_addr = rd_addr ^ (32'h1 << ($urandom % 32));
      endcase
      step("R6");
    end
    // R7: general random traffic
    for (int i = 0; i < 300; i++) begin
      cas_req = ($urandom % 5 == 0); cas_bank = 3'($urandom);
      rd_req = ($urandom % 2 == 0); rd_addr = {30'h0, 2'($urandom)}; rd_bank = 3'($urandom);
      wr_req = ($urandom % 2 == 0); wr_addr = {30'h0, 2'($urandom)}; wr_bank = 3'($urandom);
      step("R7");
    end
    idle();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired at cyc=%0d actual=hung expected=finished", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule